// File: doc/BRIEF.md
# Real-Time Clock Interrupt Unit

This block counts the time of day in seconds, minutes and hours (24-hour form), advancing by one second on each pulse of a one-second tick input. The prescaler that makes the tick sits outside the block. Software reaches the block through a small write port. Through it, software loads the three time counters, an alarm hour, an alarm minute, and a control byte that holds the enables and the event flags.

There are three event sources. The daily source fires when the hour count rolls over from 23 to 0. The per-second source fires on every tick. The alarm source fires while the alarm hour and alarm minute both equal the current hour and minute. Each source has its own enable and its own flag, and software clears each flag. The flags that are enabled are ORed together and gated by the processor's global interrupt mask to form a single interrupt request.

The alarm flag follows the compare as a level. While the alarm still equals the time, a software clear is overridden. Software can end an alarm early by writing a different alarm value.

Top module: `rtc_irq_unit`

## Requirements
- R1: While `rstN` is low and after it is released, the time reads 00:00:00, `statusOut` reads 0x00 and `irqReq` is 0.
- R2: Each cycle with `tickSec` high and no time-register write advances the seconds. Seconds wrap from 59 to 0 and carry into the minutes. Minutes wrap from 59 to 0 and carry into the hours. Hours wrap from 23 to 0. The new time is visible after that clock edge.
- R3: With the daily enable (`statusOut` bit 0) set, the daily flag (`statusOut` bit 4) sets on the edge where counting takes the time from 23:59:59 to 00:00:00. Writing the hour register from 23 to 0 does not set it.
- R4: With the seconds enable (`statusOut` bit 1) set, the seconds flag (`statusOut` bit 5) sets on every edge where `tickSec` is high.
- R5: With the alarm enable (`statusOut` bit 2) set, the alarm flag (`statusOut` bit 6) sets one edge after the alarm hour and the alarm minute both equal the current hour and minute. A match on the hour alone does not set it.
- R6: While the alarm is enabled and still matches, a clear of the alarm flag has no effect. Once a new alarm value removes the match, the next clear takes the flag to 0.
- R7: A flag never sets while its enable is 0.
- R8: Write addresses are 0 seconds, 1 minutes, 2 hours, 3 alarm minute, 4 alarm hour, 5 control. A control write loads the enables from data bits 2:0 (bit 0 daily, bit 1 seconds, bit 2 alarm). A 1 in data bit 4, 5 or 6 clears the daily, seconds or alarm flag. A 0 in those bits leaves the flag unchanged. A flag that sets in the same cycle wins over a clear.
- R9: `irqReq` is 1 exactly when `cpuMask` is 0 and at least one source has both its enable and its flag set. It responds in the same cycle to a change of `cpuMask`.
- R10: When a time register is written in the same cycle as a tick, the written value is loaded, and that tick does not advance or carry into any time register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickSec | input | 1 | One-cycle pulse per elapsed second |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register write address |
| wrData | input | 8 | Register write data |
| cpuMask | input | 1 | Global interrupt mask, 1 blocks the request |
| irqReq | output | 1 | Combined interrupt request |
| curSec | output | 6 | Current seconds |
| curMin | output | 6 | Current minutes |
| curHour | output | 5 | Current hours |
| statusOut | output | 8 | Enables in bits 2:0, flags in bits 6:4 |

## Verification
A wrong count or carry shows on `curSec`, `curMin` or `curHour` one edge after the tick that caused it. Because the bench sweeps a full day one tick per cycle, any faulty wrap point shows up within that single pass. A flag that sets wrongly, clears wrongly or escapes its enable shows on `statusOut` one edge later, and on `irqReq` in the same cycle whenever the mask is open. The alarm case is checked across the whole set, clear and rewrite sequence, so a flag built as an edge event rather than a level shows up as a flag that clears too early.

// File: rtl/rtc_pkg.sv
package rtc_pkg;
  localparam int NSRC = 3;
  localparam int SRC_DAY = 0;
  localparam int SRC_SEC = 1;
  localparam int SRC_ALM = 2;
  localparam int FLAG_LSB = 4;

  localparam logic [2:0] ADDR_SEC = 3'd0;
  localparam logic [2:0] ADDR_MIN = 3'd1;
  localparam logic [2:0] ADDR_HOUR = 3'd2;
  localparam logic [2:0] ADDR_ALM_MIN = 3'd3;
  localparam logic [2:0] ADDR_ALM_HOUR = 3'd4;
  localparam logic [2:0] ADDR_CTRL = 3'd5;

  typedef struct packed {
    logic ldSec;
    logic ldMin;
    logic ldHour;
    logic ldAlmMin;
    logic ldAlmHour;
    logic ldCtrl;
    logic advance;
  } rtcStrobe_t;
endpackage

// File: rtl/rtc_datapath.sv
module rtc_datapath
  import rtc_pkg::*;
#(
  parameter int SECS = 60,
  parameter int MINS = 60,
  parameter int HOURS = 24,
  parameter int DW = 8,
  localparam int SW = $clog2(SECS),
  localparam int MW = $clog2(MINS),
  localparam int HW = $clog2(HOURS)
) (
  input  logic clk,
  input  logic rstN,
  input  rtcStrobe_t stb,
  input  logic [DW-1:0] wrData,
  output logic [SW-1:0] curSec,
  output logic [MW-1:0] curMin,
  output logic [HW-1:0] curHour,
  output logic dayWrap,
  output logic almMatch
);
  logic [MW-1:0] almMin;
  logic [HW-1:0] almHour;
  logic secLast, minLast, hourLast;
  logic unusedData;

  assign unusedData = ^wrData;
  assign secLast = (curSec >= SW'(SECS - 1));
  assign minLast = (curMin >= MW'(MINS - 1));
  assign hourLast = (curHour >= HW'(HOURS - 1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curSec <= '0;
      curMin <= '0;
      curHour <= '0;
      almMin <= '0;
      almHour <= '0;
    end else begin
      if (stb.ldSec) curSec <= wrData[SW-1:0];
      else if (stb.advance) curSec <= secLast ? '0 : curSec + 1'b1;

      if (stb.ldMin) curMin <= wrData[MW-1:0];
      else if (stb.advance && secLast) curMin <= minLast ? '0 : curMin + 1'b1;

      if (stb.ldHour) curHour <= wrData[HW-1:0];
      else if (stb.advance && secLast && minLast) curHour <= hourLast ? '0 : curHour + 1'b1;

      if (stb.ldAlmMin) almMin <= wrData[MW-1:0];
      if (stb.ldAlmHour) almHour <= wrData[HW-1:0];
    end
  end

  assign dayWrap = stb.advance && secLast && minLast && hourLast;
  assign almMatch = (almHour == curHour) && (almMin == curMin);

  // R2
  sec_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.advance && !stb.ldSec && !secLast) |=> (curSec == SW'($past(curSec) + 1'b1)));

  // R10
  load_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    stb.ldSec |=> (curSec == $past(wrData[SW-1:0])));
endmodule

// File: rtl/rtc_ctrl.sv
module rtc_ctrl
  import rtc_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickSec,
  input  logic wrEn,
  input  logic [2:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic cpuMask,
  input  logic dayWrap,
  input  logic almMatch,
  output rtcStrobe_t stb,
  output logic [NSRC-1:0] srcEn,
  output logic [NSRC-1:0] srcFlag,
  output logic irqReq
);
  logic [NSRC-1:0] setVec;
  logic timeWr;
  logic unusedData;

  assign unusedData = ^wrData;

  always_comb begin
    stb = '0;
    if (wrEn) begin
      case (wrAddr)
        ADDR_SEC:      stb.ldSec = 1'b1;
        ADDR_MIN:      stb.ldMin = 1'b1;
        ADDR_HOUR:     stb.ldHour = 1'b1;
        ADDR_ALM_MIN:  stb.ldAlmMin = 1'b1;
        ADDR_ALM_HOUR: stb.ldAlmHour = 1'b1;
        ADDR_CTRL:     stb.ldCtrl = 1'b1;
        default: ;
      endcase
    end
    timeWr = stb.ldSec | stb.ldMin | stb.ldHour;
    stb.advance = tickSec && !timeWr;
  end

  always_comb begin
    setVec = '0;
    setVec[SRC_DAY] = dayWrap;
    setVec[SRC_SEC] = tickSec;
    setVec[SRC_ALM] = almMatch;
  end

  always_ff @(posedge clk) begin
    if (!rstN) srcEn <= '0;
    else if (stb.ldCtrl) srcEn <= wrData[NSRC-1:0];
  end

  for (genvar g = 0; g < NSRC; g++) begin : gFlag
    always_ff @(posedge clk) begin
      if (!rstN) srcFlag[g] <= 1'b0;
      else if (srcEn[g] && setVec[g]) srcFlag[g] <= 1'b1;
      else if (stb.ldCtrl && wrData[FLAG_LSB+g]) srcFlag[g] <= 1'b0;
    end
  end

  assign irqReq = !cpuMask && |(srcEn & srcFlag);

  // R6
  alarm_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn[SRC_ALM] && almMatch) |=> srcFlag[SRC_ALM]);

  // R3
  day_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcEn[SRC_DAY] && dayWrap) |=> srcFlag[SRC_DAY]);

  // R7
  sec_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!srcEn[SRC_SEC] && !srcFlag[SRC_SEC]) |=> !srcFlag[SRC_SEC]);

  // R8
  w1c_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stb.ldCtrl && wrData[FLAG_LSB+SRC_SEC] && !(srcEn[SRC_SEC] && tickSec))
      |=> !srcFlag[SRC_SEC]);
endmodule

// File: rtl/rtc_irq_unit.sv
module rtc_irq_unit
  import rtc_pkg::*;
#(
  parameter int SECS = 60,
  parameter int MINS = 60,
  parameter int HOURS = 24,
  parameter int DW = 8,
  localparam int SW = $clog2(SECS),
  localparam int MW = $clog2(MINS),
  localparam int HW = $clog2(HOURS)
) (
  input  logic clk,
  input  logic rstN,
  input  logic tickSec,
  input  logic wrEn,
  input  logic [2:0] wrAddr,
  input  logic [DW-1:0] wrData,
  input  logic cpuMask,
  output logic irqReq,
  output logic [SW-1:0] curSec,
  output logic [MW-1:0] curMin,
  output logic [HW-1:0] curHour,
  output logic [7:0] statusOut
);
  rtcStrobe_t stb;
  logic dayWrap, almMatch;
  logic [NSRC-1:0] srcEn, srcFlag;

  rtc_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cpuMask(cpuMask), .dayWrap(dayWrap), .almMatch(almMatch),
    .stb(stb), .srcEn(srcEn), .srcFlag(srcFlag), .irqReq(irqReq)
  );

  rtc_datapath #(.SECS(SECS), .MINS(MINS), .HOURS(HOURS), .DW(DW)) uData (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .curSec(curSec), .curMin(curMin), .curHour(curHour),
    .dayWrap(dayWrap), .almMatch(almMatch)
  );

  assign statusOut = {1'b0, srcFlag, 1'b0, srcEn};

  // R9
  mask_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    cpuMask |-> !irqReq);
endmodule

// File: tb/rtc_irq_unit_test.sv
`timescale 1ns/1ps
module rtc_irq_unit_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic tickSec = 1'b0;
  logic wrEn = 1'b0;
  logic [2:0] wrAddr = '0;
  logic [7:0] wrData = '0;
  logic cpuMask = 1'b1;
  logic irqReq;
  logic [5:0] curSec, curMin;
  logic [4:0] curHour;
  logic [7:0] statusOut;

  int nVec = 0;
  int nBad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rtc_irq_unit uut (
    .clk(clk), .rstN(rstN), .tickSec(tickSec), .wrEn(wrEn), .wrAddr(wrAddr),
    .wrData(wrData), .cpuMask(cpuMask), .irqReq(irqReq), .curSec(curSec),
    .curMin(curMin), .curHour(curHour), .statusOut(statusOut)
  );

  task automatic cyc();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d, input logic tk = 1'b0);
    wrEn = 1'b1; wrAddr = a; wrData = d; tickSec = tk;
    cyc();
    wrEn = 1'b0; tickSec = 1'b0;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] packTime(input int t);
    int w;
    w = t % 86400;
    return ((w / 3600) << 12) | (((w / 60) % 60) << 6) | (w % 60);
  endfunction

  initial begin
    repeat (195000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) cyc();
    // R1 reset state
    check("R1 time", {curHour, curMin, curSec}, 0);
    check("R1 status", {irqReq, statusOut}, 0);
    rstN = 1'b1;
    cyc();
    check("R1 after release", {irqReq, curHour, curMin, curSec, statusOut}, 0);

    // full-day sweep: R2 counting, R3 daily flag, R4 seconds flag, R7 alarm gated off
    wr(3'd5, 8'h03);
    for (int t = 1; t <= 86400; t++) begin
      tickSec = 1'b1;
      cyc();
      check("R2 time", {curHour, curMin, curSec}, packTime(t));
      check("R3/R4/R7 status", {irqReq, statusOut},
            32'h23 | ((t == 86400) ? 32'h10 : 32'h0));
    end
    tickSec = 1'b0;

    // R8 write-one-to-clear
    wr(3'd5, 8'h03);
    check("R8 zero write keeps flags", statusOut, 8'h33);
    wr(3'd5, 8'h13);
    check("R8 clear daily", statusOut, 8'h23);
    wr(3'd5, 8'h23);
    check("R8 clear seconds", statusOut, 8'h03);

    // R9 interrupt gating
    cpuMask = 1'b0; #1;
    check("R9 no flag no irq", irqReq, 0);
    tickSec = 1'b1; cyc(); tickSec = 1'b0;
    check("R4 flag after tick", statusOut, 8'h23);
    check("R9 irq open mask", irqReq, 1);
    cpuMask = 1'b1; #1;
    check("R9 mask blocks", irqReq, 0);
    cpuMask = 1'b0;
    wr(3'd5, 8'h01);
    check("R9 disabled source", {irqReq, statusOut}, 9'h021);
    wr(3'd5, 8'h21);
    check("R8 clear with enable off", statusOut, 8'h01);

    // R10 write wins over tick
    wr(3'd0, 8'd10, 1'b1);
    check("R10 write priority", {curHour, curMin, curSec}, packTime(10 + 60 * 0));

    // R3 hour write does not set daily flag
    wr(3'd2, 8'd23);
    wr(3'd2, 8'd0);
    check("R3 write wrap ignored", {curHour, statusOut}, {5'd0, 8'h01});

    // R5/R6 alarm
    wr(3'd4, 8'd7);
    wr(3'd3, 8'd30);
    wr(3'd2, 8'd7);
    wr(3'd1, 8'd29);
    wr(3'd0, 8'd59);
    wr(3'd5, 8'h04);
    cyc();
    check("R5 hour only no alarm", {irqReq, statusOut}, 9'h004);
    tickSec = 1'b1; cyc(); tickSec = 1'b0;
    check("R2 carry to 07:30:00", {curHour, curMin, curSec}, packTime(7 * 3600 + 30 * 60));
    cyc();
    check("R5 alarm flag", {irqReq, statusOut}, 9'h144);
    wr(3'd5, 8'h44);
    check("R6 clear overridden", statusOut, 8'h44);
    cyc();
    check("R6 still set", statusOut, 8'h44);
    wr(3'd3, 8'd31);
    check("R6 set on rewrite edge", statusOut, 8'h44);
    wr(3'd5, 8'h44);
    check("R6 clear after mismatch", {irqReq, statusOut}, 9'h004);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end
endmodule